// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block brings an asynchronous DRAM out of power-up and keeps its contents alive. After reset it stays off the bus for a programmable startup wait. It then runs a fixed burst of refresh cycles on its own, without asking for the bus, and raises `ready` once the last cycle of that burst has finished its precharge. From then on a timer posts one refresh request for each slice of the retention period. A request stays up until the access sequencer grants the bus. The block then drives the DRAM strobes and address itself for one complete refresh cycle.

Each refresh is one of two kinds, picked by `ras_only_mode` when the cycle starts. The first kind drops the column strobe ahead of the row strobe, so the DRAM uses its own row counter. The second presents a row number from an internal counter and pulses only the row strobe. All strobe widths come from nanosecond parameters and the clock period. With an 8 ns clock the defaults give one cycle of setup, eight cycles with the row strobe low and five cycles of precharge: 14 cycles in total.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `ras_n`, `cas_n` and `we_n` are 1 and `ready`, `ref_req`, `missed` and `drive_en` are 0.
- R2: After `rst_n` is released, the block leaves the bus untouched for STARTUP_CYCLES cycles (`drive_en` 0, both strobes high). `drive_en` goes high in the cycle after that.
- R3: After the startup wait, the block runs exactly INIT_REFRESHES refresh cycles back to back without a grant. `ready` goes high in the cycle after the last precharge and stays high until the next reset.
- R4: Once `ready` is high, a refresh falls due every INTERVAL_CYC = floor(RETENTION_NS / 2^ROW_BITS / CLK_PERIOD_NS) cycles. The first request appears INTERVAL_CYC cycles after `ready` rises.
- R5: `ref_req` is high only while the block is idle with at least one refresh owed, and it stays high until `ref_grant` is seen. A grant seen while `ref_req` is low starts nothing.
- R6: A refresh with `ras_only_mode`=0 starts in the cycle after the grant. `cas_n` is low for 1 cycle before `ras_n` falls. `ras_n` then stays low for 8 cycles with `cas_n` still low. Both strobes are then high for 5 precharge cycles while `drive_en` stays 1. `we_n` is 1 throughout, and `drive_en` drops in the 15th cycle after the grant.
- R7: A refresh with `ras_only_mode`=1 has the same strobe timing for `ras_n`, with `cas_n` held at 1 throughout. `addr` carries the row counter from the setup cycle to the end of the low phase, and is 0 at all other times.
- R8: The 11-bit row counter starts at 0 and advances by one after each row-address refresh, including those in the initialization burst. It wraps from 2047 to 0. A column-first refresh leaves it unchanged.
- R9: At most PEND_MAX (2) refreshes are owed at once. If an interval ends while that many are already owed, `missed` is set and stays set until reset. The owed count is capped and does not grow.
- R10: The refresh kind is latched when a cycle starts. A change of `ras_only_mode` during the cycle does not change that cycle's strobes or address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_only_mode | input | 1 | 1 selects row-address refresh, 0 selects column-first refresh |
| ref_grant | input | 1 | Bus granted by the access sequencer |
| ref_req | output | 1 | Refresh owed and waiting for the bus |
| ready | output | 1 | Initialization finished |
| missed | output | 1 | Sticky flag: a refresh was dropped at the cap |
| drive_en | output | 1 | The block owns the DRAM control and address lines |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_BITS | Row address during row-address refresh |

## Verification
The bench checks the exact cycle at which `drive_en` first rises and the exact cycle at which `ready` rises. A scheduler that miscounts the startup wait or the burst length would touch the DRAM early, or would report ready one cycle off. The bench also counts the row strobe pulses in the burst. The strobe order in both refresh kinds is compared cycle by cycle at the edges of each phase. An off-by-one phase counter, or a column strobe that fires during row-address refresh, would show up there. The bench withholds grants until the owed count reaches the cap, which exposes a flag that is set one interval late or a count that wraps. It also runs the row counter through its 2047-to-0 wrap and flips the mode pin in the middle of a cycle to catch a kind that is not latched.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int CLK_PERIOD_NS  = 8,
  parameter int STARTUP_CYCLES = 25_000_000,
  parameter int INIT_REFRESHES = 8,
  parameter int ROW_BITS       = 11,
  parameter int RETENTION_NS   = 32_000_000,
  parameter int PEND_MAX       = 2,
  parameter int T_RAS_NS       = 60,
  parameter int T_RP_NS        = 40,
  parameter int T_RC_NS        = 104,
  parameter int T_CSR_NS       = 5,
  parameter int T_CHR_NS       = 10,
  parameter int T_ASR_NS       = 0,
  parameter int T_RAH_NS       = 10,
  parameter int T_RPC_NS       = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_only_mode,
  input  logic                ref_grant,
  output logic                ref_req,
  output logic                ready,
  output logic                missed,
  output logic                drive_en,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [ROW_BITS-1:0] addr
);

  function automatic int cdiv(input int ns);
    return (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SETUP_CYC    = max2(1, max2(cdiv(T_CSR_NS), cdiv(T_ASR_NS)));
  localparam int LOW_CYC      = max2(cdiv(T_RAS_NS), max2(cdiv(T_CHR_NS), cdiv(T_RAH_NS)));
  localparam int PRE_CYC      = max2(max2(cdiv(T_RP_NS), cdiv(T_RPC_NS)),
                                     cdiv(T_RC_NS) - LOW_CYC);
  localparam int INTERVAL_NS  = RETENTION_NS / (1 << ROW_BITS);
  localparam int INTERVAL_CYC = INTERVAL_NS / CLK_PERIOD_NS;
  localparam int PH_W   = $clog2(max2(SETUP_CYC, max2(LOW_CYC, PRE_CYC)) + 1);
  localparam int WAIT_W = $clog2(STARTUP_CYCLES + 1);
  localparam int TICK_W = $clog2(INTERVAL_CYC + 1);
  localparam int INIT_W = $clog2(INIT_REFRESHES + 1);
  localparam int PEND_W = $clog2(PEND_MAX + 1);

  typedef enum logic [2:0] {S_WAIT, S_IDLE, S_SETUP, S_LOW, S_PRE} state_t;

  state_t              state;
  logic [PH_W-1:0]     ph;
  logic [WAIT_W-1:0]   wait_cnt;
  logic [TICK_W-1:0]   tick_cnt;
  logic [INIT_W-1:0]   init_left;
  logic [PEND_W-1:0]   pending;
  logic [ROW_BITS-1:0] row;
  logic                mode_q;
  logic                tick, start, in_cycle, strobe_phase;

  assign in_cycle     = (state == S_SETUP) || (state == S_LOW) || (state == S_PRE);
  assign strobe_phase = (state == S_SETUP) || (state == S_LOW);
  assign ref_req      = ready && (state == S_IDLE) && (pending != '0);
  assign start        = ref_req && ref_grant;
  assign tick         = ready && (tick_cnt == TICK_W'(INTERVAL_CYC - 1));

  assign drive_en = in_cycle;
  assign ras_n    = (state != S_LOW);
  assign cas_n    = !(!mode_q && strobe_phase);
  assign we_n     = 1'b1;
  assign addr     = (mode_q && strobe_phase) ? row : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_WAIT;
      ph        <= '0;
      wait_cnt  <= '0;
      init_left <= INIT_W'(INIT_REFRESHES);
      row       <= '0;
      mode_q    <= 1'b0;
      ready     <= 1'b0;
    end else begin
      case (state)
        S_WAIT: begin
          if (wait_cnt == WAIT_W'(STARTUP_CYCLES - 1)) begin
            state  <= S_SETUP;
            mode_q <= ras_only_mode;
            ph     <= '0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        S_IDLE: begin
          if (start) begin
            state  <= S_SETUP;
            mode_q <= ras_only_mode;
            ph     <= '0;
          end
        end
        S_SETUP: begin
          if (ph == PH_W'(SETUP_CYC - 1)) begin
            state <= S_LOW;
            ph    <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_LOW: begin
          if (ph == PH_W'(LOW_CYC - 1)) begin
            state <= S_PRE;
            ph    <= '0;
            if (mode_q) row <= row + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_PRE: begin
          if (ph == PH_W'(PRE_CYC - 1)) begin
            ph <= '0;
            if (init_left > INIT_W'(1)) begin
              init_left <= init_left - 1'b1;
              state     <= S_SETUP;
              mode_q    <= ras_only_mode;
            end else begin
              if (init_left == INIT_W'(1)) ready <= 1'b1;
              init_left <= '0;
              state     <= S_IDLE;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      pending  <= '0;
      missed   <= 1'b0;
    end else begin
      if (tick)       tick_cnt <= '0;
      else if (ready) tick_cnt <= tick_cnt + 1'b1;
      case ({tick, start})
        2'b10: begin
          if (pending == PEND_W'(PEND_MAX)) missed <= 1'b1;
          else pending <= pending + 1'b1;
        end
        2'b01:   pending <= pending - 1'b1;
        default: ;
      endcase
    end
  end

  assert_quiet_before_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !drive_en) |-> (ras_n && cas_n));
  assert_cas_leads_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));
  assert_we_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> we_n);
  assert_row_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(!ras_n)) |-> $stable(addr));
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_grant) |=> ref_req);
  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  assert_missed_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    missed |=> missed);
  assert_pending_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= PEND_W'(PEND_MAX));

endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int STARTUP = 20;
  localparam int INTERVAL = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_only_mode = 1'b1;
  logic ref_grant = 1'b0;
  logic ref_req, ready, missed, drive_en, ras_n, cas_n, we_n;
  logic [10:0] addr;

  int total = 0;
  int fails = 0;
  int exp_row = 0;

  always #4 clk = ~clk;

  dram_refresh_sched #(
    .CLK_PERIOD_NS(8), .STARTUP_CYCLES(STARTUP), .INIT_REFRESHES(8),
    .ROW_BITS(11), .RETENTION_NS(INTERVAL * 8 * 2048), .PEND_MAX(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_only_mode(ras_only_mode), .ref_grant(ref_grant),
    .ref_req(ref_req), .ready(ready), .missed(missed), .drive_en(drive_en),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr)
  );

  // {mode, offset after grant, ras_n, cas_n, drive_en}
  localparam logic [8:0] VEC [12] = '{
    {1'b0, 5'd1,  3'b101}, {1'b0, 5'd2,  3'b001}, {1'b0, 5'd9,  3'b001},
    {1'b0, 5'd10, 3'b111}, {1'b0, 5'd14, 3'b111}, {1'b0, 5'd15, 3'b110},
    {1'b1, 5'd1,  3'b111}, {1'b1, 5'd2,  3'b011}, {1'b1, 5'd9,  3'b011},
    {1'b1, 5'd10, 3'b111}, {1'b1, 5'd14, 3'b111}, {1'b1, 5'd15, 3'b110}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_req();
    while (!ref_req) @(negedge clk);
  endtask

  task automatic grant_once(input logic mode);
    ras_only_mode = mode;
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int falls;
    logic prev_ras;
    repeat (5) @(negedge clk);
    chk("R1 strobes", {ras_n, cas_n, we_n}, 3'b111);
    chk("R1 flags", {ready, ref_req, missed, drive_en}, 4'b0000);
    rst_n = 1'b1;
    ras_only_mode = 1'b1;

    repeat (STARTUP - 1) @(negedge clk);
    chk("R2 idle bus at end of wait", {drive_en, ras_n, cas_n}, 3'b011);
    @(negedge clk);
    chk("R2 bus taken after wait", drive_en, 1'b1);

    falls = 0;
    prev_ras = ras_n;
    for (int c = STARTUP + 1; c <= 131; c++) begin
      @(negedge clk);
      if (prev_ras && !ras_n) falls++;
      prev_ras = ras_n;
    end
    chk("R3 ready low before burst end", ready, 1'b0);
    chk("R3 burst length", falls, 8);
    @(negedge clk);
    chk("R3 ready after burst", ready, 1'b1);
    exp_row = 8;

    repeat (INTERVAL - 1) @(negedge clk);
    chk("R4 no request early", ref_req, 1'b0);
    @(negedge clk);
    chk("R4 request on interval", ref_req, 1'b1);

    for (int i = 0; i < 12; i++) begin
      logic m;
      int off;
      int ea;
      m = VEC[i][8];
      off = int'(VEC[i][7:3]);
      wait_req();
      grant_once(m);
      repeat (off - 1) @(negedge clk);
      ea = (m && off <= 9) ? exp_row : 0;
      if (m) begin
        chk("R7 row-address strobes", {ras_n, cas_n, drive_en}, VEC[i][2:0]);
        chk("R7 R8 row address", addr, ea);
      end else begin
        chk("R6 column-first strobes", {ras_n, cas_n, drive_en}, VEC[i][2:0]);
        chk("R8 no address on column-first", addr, 0);
      end
      chk("R6 we high", we_n, 1'b1);
      if (m) exp_row = (exp_row + 1) % 2048;
    end

    wait_req();
    grant_once(1'b0);
    repeat (14) @(negedge clk);
    ref_grant = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 grant without request ignored", {ras_n, cas_n, drive_en}, 3'b110);
    ref_grant = 1'b0;

    wait_req();
    grant_once(1'b0);
    @(negedge clk);
    ras_only_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 kind latched cas", cas_n, 1'b0);
    chk("R10 kind latched addr", addr, 0);
    repeat (12) @(negedge clk);

    wait_req();
    grant_once(1'b1);
    exp_row = (exp_row + 1) % 2048;
    repeat (14) @(negedge clk);
    wait_req();
    repeat (INTERVAL * 2 - 1) @(negedge clk);
    chk("R9 no flag before cap overflow", missed, 1'b0);
    chk("R5 request held", ref_req, 1'b1);
    @(negedge clk);
    chk("R9 missed flag set", missed, 1'b1);
    grant_once(1'b0);
    repeat (14) @(negedge clk);
    chk("R9 capped owed count second request", ref_req, 1'b1);
    grant_once(1'b0);
    repeat (14) @(negedge clk);
    chk("R9 owed count drained", ref_req, 1'b0);
    chk("R9 missed sticky", missed, 1'b1);

    while (exp_row != 2047) begin
      wait_req();
      grant_once(1'b1);
      exp_row++;
    end
    wait_req();
    grant_once(1'b1);
    chk("R8 row before wrap", addr, 2047);
    wait_req();
    grant_once(1'b1);
    chk("R8 row wraps to zero", addr, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule